// File: doc/BRIEF.md
# Masked Register Update Master

This block sits on the host side of a memory-mapped control/status register port that stalls requests with a waitrequest signal and returns read data later, marked by a separate valid strobe. A local command interface issues one of three operations: a plain single read, a plain single write, or a masked update. For a masked update the block reads the addressed word, replaces only the bits selected by the mask with the supplied new bits, and writes the whole word back.

Each command is captured into registers when it is accepted. The transaction then runs to completion whatever the stall pattern or read latency. A busy output covers the whole transaction, and a one-cycle done pulse marks its end. The last word read from the port stays on a result output until the next read replaces it. Commands that arrive while the block is busy are dropped. The block never raises a read and a write together, and never has more than one read in flight.

Top module: `csr_rmw_master`

## Requirements
- R1: While reset is asserted and after it is released, bus_read, bus_write, busy and done are low, bus_byteen is 0, and result and bus_addr are 0.
- R2: A command is taken only when cmd_valid is high and busy is low. cmd_op codes are 0 = read, 1 = write, 2 = masked update, and 3 = no operation, which is ignored. A command offered while busy starts no transaction and does not change bus_addr.
- R3: bus_read rises in the cycle after the command is taken. It stays high, with bus_addr unchanged, in every cycle where bus_waitreq is high, and it drops on the clock after a cycle with bus_read high and bus_waitreq low.
- R4: bus_write stays high, with bus_addr and bus_wdata unchanged, in every cycle where bus_waitreq is high, and it drops on the clock after a cycle with bus_write high and bus_waitreq low.
- R5: Read data is captured only in a cycle with bus_rdata_valid high that comes after the read was accepted and before any later valid pulse. A valid pulse at any other time is ignored.
- R6: bus_read and bus_write are never high in the same cycle. During a masked update, the write starts only after the read data has been captured.
- R7: The word written by a masked update is (old & ~mask) | (new & mask), and bus_byteen is 4'hF whenever a request is raised.
- R8: A plain read raises no write. After the read data is captured, done pulses on the next cycle, and result then holds the word that was read.
- R9: A plain write raises no read and writes cmd_data unchanged to the captured address.
- R10: busy is high from the cycle after a command is taken through the cycle of done. done is high for exactly one cycle per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command offer |
| cmd_op | input | 2 | Operation code: 0 read, 1 write, 2 masked update, 3 none |
| cmd_addr | input | 14 | Register word address |
| cmd_mask | input | 32 | Bit-select mask for masked update |
| cmd_data | input | 32 | New bits (update) or full word (write) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Last word read from the port |
| bus_addr | output | 14 | Port address |
| bus_read | output | 1 | Read request |
| bus_write | output | 1 | Write request |
| bus_byteen | output | 4 | Byte enables |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_rdata_valid | input | 1 | Read data valid strobe |
| bus_waitreq | input | 1 | Slave stall |

## Verification
The hardest case to reach is a masked update in which several things line up at once. The read is stalled from its first cycle, its data returns after a gap, a stray valid pulse arrives outside the wait window, and a new command is offered in the same cycles. The bench model of the slave raises waitrequest in the same cycle a request appears, using a stall count drawn anew for each request. It also stalls while the port is idle, returns data after a random latency, and injects stray valid pulses only while no read is awaiting data. Meanwhile commands, including the no-op code, are offered on random cycles whether or not the block is busy.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_RD_REQ  = 3'd1,
    S_RD_WAIT = 3'd2,
    S_WR_REQ  = 3'd3,
    S_DONE    = 3'd4
  } state_e;

endpackage

// File: rtl/csr_rmw_rst_sync.sv
module csr_rmw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/csr_rmw_capture.sv
module csr_rmw_capture
  import csr_rmw_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_load,
  input  op_e           op_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] mask_in,
  input  logic [DW-1:0] data_in,
  input  logic          rd_load,
  input  logic [DW-1:0] rd_in,
  output op_e           op_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] rd_q
);

  op_e           op_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] mask_d, data_d, rd_d;

  always_comb begin
    op_d   = op_q;
    addr_d = addr_q;
    mask_d = mask_q;
    data_d = data_q;
    rd_d   = rd_q;
    if (cmd_load) begin
      op_d   = op_in;
      addr_d = addr_in;
      mask_d = mask_in;
      data_d = data_in;
    end
    if (rd_load) rd_d = rd_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      mask_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      mask_q <= mask_d;
      data_q <= data_d;
      rd_q   <= rd_d;
    end
  end

  // Captured command fields stay frozen unless a new command is loaded
  assert_cmd_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_load |=> $stable(addr_q) && $stable(mask_q) && $stable(data_q));

endmodule

// File: rtl/csr_rmw_merge.sv
module csr_rmw_merge #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] new_bits,
  output logic [DW-1:0] merged
);

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign merged[b] = mask[b] ? new_bits[b] : old_word[b];
  end

endmodule

// File: rtl/csr_rmw_seq.sv
module csr_rmw_seq
  import csr_rmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  op_e  cmd_op,
  input  op_e  op_q,
  input  logic waitreq,
  input  logic rdata_valid,
  output logic cmd_load,
  output logic rd_load,
  output logic rd_req,
  output logic wr_req,
  output logic busy,
  output logic done
);

  state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cmd_load = 1'b0;
    rd_load  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_valid && cmd_op != OP_NONE) begin
          cmd_load = 1'b1;
          state_d  = (cmd_op == OP_WRITE) ? S_WR_REQ : S_RD_REQ;
        end
      end
      S_RD_REQ: begin
        if (!waitreq) state_d = S_RD_WAIT;
      end
      S_RD_WAIT: begin
        if (rdata_valid) begin
          rd_load = 1'b1;
          state_d = (op_q == OP_RMW) ? S_WR_REQ : S_DONE;
        end
      end
      S_WR_REQ: begin
        if (!waitreq) state_d = S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign rd_req = (state_q == S_RD_REQ);
  assign wr_req = (state_q == S_WR_REQ);
  assign busy   = (state_q != S_IDLE);
  assign done   = (state_q == S_DONE);

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && waitreq |=> rd_req);
  assert_rd_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !waitreq |=> !rd_req);
  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && waitreq |=> wr_req);
  assert_wr_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !waitreq |=> !wr_req);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> busy);

endmodule

// File: rtl/csr_rmw_master.sv
module csr_rmw_master
  import csr_rmw_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_mask,
  input  logic [DW-1:0] cmd_data,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic [AW-1:0] bus_addr,
  output logic          bus_read,
  output logic          bus_write,
  output logic [DW/8-1:0] bus_byteen,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdata_valid,
  input  logic          bus_waitreq
);

  localparam int BEW = DW / 8;

  logic          rst_sync_n;
  logic          cmd_load, rd_load;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] mask_q, data_q, rd_q, merged;

  csr_rmw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  csr_rmw_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (op_e'(cmd_op)),
    .op_q        (op_q),
    .waitreq     (bus_waitreq),
    .rdata_valid (bus_rdata_valid),
    .cmd_load    (cmd_load),
    .rd_load     (rd_load),
    .rd_req      (bus_read),
    .wr_req      (bus_write),
    .busy        (busy),
    .done        (done)
  );

  csr_rmw_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_load (cmd_load),
    .op_in    (op_e'(cmd_op)),
    .addr_in  (cmd_addr),
    .mask_in  (cmd_mask),
    .data_in  (cmd_data),
    .rd_load  (rd_load),
    .rd_in    (bus_rdata),
    .op_q     (op_q),
    .addr_q   (addr_q),
    .mask_q   (mask_q),
    .data_q   (data_q),
    .rd_q     (rd_q)
  );

  csr_rmw_merge #(.DW(DW)) u_merge (
    .old_word (rd_q),
    .mask     (mask_q),
    .new_bits (data_q),
    .merged   (merged)
  );

  assign bus_addr   = addr_q;
  assign bus_wdata  = (op_q == OP_WRITE) ? data_q : merged;
  assign bus_byteen = (bus_read || bus_write) ? {BEW{1'b1}} : {BEW{1'b0}};
  assign result     = rd_q;

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_read && bus_write));
  assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_read || bus_write) && bus_waitreq |=> $stable(bus_addr) && $stable(bus_wdata));
  assert_busy_ignores_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy && cmd_valid |=> $stable(bus_addr));
  assert_byteen_full_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_write |-> bus_byteen == {BEW{1'b1}});

endmodule

// File: tb/csr_rmw_master_tb.sv
module csr_rmw_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 8000;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [13:0] cmd_addr = '0;
  logic [31:0] cmd_mask = '0;
  logic [31:0] cmd_data = '0;
  logic        busy, done;
  logic [31:0] result;
  logic [13:0] bus_addr;
  logic        bus_read, bus_write;
  logic [3:0]  bus_byteen;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_rdata_valid = 1'b0;
  logic        bus_waitreq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_rmw_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_mask(cmd_mask), .cmd_data(cmd_data),
    .busy(busy), .done(done), .result(result), .bus_addr(bus_addr),
    .bus_read(bus_read), .bus_write(bus_write), .bus_byteen(bus_byteen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_valid(bus_rdata_valid), .bus_waitreq(bus_waitreq)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit run = 0;
  int mode = 0;  // 0 fast slave, 1 stalling slave

  // reference model state
  int          m_ph = 0;  // 0 idle,1 read asked,2 data awaited,3 write asked,4 finished
  int          m_op = 3;
  logic [13:0] m_addr = '0;
  logic [31:0] m_mask = '0, m_data = '0, m_rd = '0;

  // slave model state
  logic [31:0] mem [16];
  bit          req_prev = 0;
  int          stall_left = 0;
  bit          pend = 0;
  int          lat_left = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s got %0h exp %0h at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  // model and slave bookkeeping at the clock edge, using inputs set at negedge
  always @(posedge clk) begin
    cycles++;
    if (bus_write && !bus_waitreq) mem[bus_addr[3:0]] = bus_wdata;
    if (bus_read && !bus_waitreq) begin
      pend = 1;
      lat_left = (mode == 0) ? 0 : int'($urandom_range(0, 5));
    end
    if (!rst_n) begin
      m_ph = 0; m_op = 3; m_addr = '0; m_mask = '0; m_data = '0; m_rd = '0;
    end else begin
      case (m_ph)
        0: if (cmd_valid && cmd_op != 2'd3) begin
             m_op = cmd_op; m_addr = cmd_addr; m_mask = cmd_mask; m_data = cmd_data;
             m_ph = (cmd_op == 2'd1) ? 3 : 1;
           end
        1: if (!bus_waitreq) m_ph = 2;
        2: if (bus_rdata_valid) begin
             m_rd = bus_rdata;
             m_ph = (m_op == 2) ? 3 : 4;
           end
        3: if (!bus_waitreq) m_ph = 4;
        default: m_ph = 0;
      endcase
    end
  end

  // compare outputs, then drive the next cycle's inputs
  always @(negedge clk) begin
    string t;
    logic [31:0] exp_w;
    bit req_now;
    t = rst_n ? "" : "R1";
    chk(rst_n ? "R3" : t, "bus_read", 32'(bus_read), 32'(m_ph == 1));
    chk(rst_n ? "R4" : t, "bus_write", 32'(bus_write), 32'(m_ph == 3));
    chk(rst_n ? "R10" : t, "busy", 32'(busy), 32'(m_ph != 0));
    chk(rst_n ? "R10" : t, "done", 32'(done), 32'(m_ph == 4));
    chk(rst_n ? "R8" : t, "result", result, m_rd);
    chk(rst_n ? "R2" : t, "bus_addr", 32'(bus_addr), 32'(m_addr));
    chk(rst_n ? "R7" : t, "bus_byteen", 32'(bus_byteen),
        (m_ph == 1 || m_ph == 3) ? 32'hF : 32'h0);
    if (bus_read && bus_write) chk("R6", "overlap", 32'd1, 32'd0);
    if (m_ph == 3) begin
      exp_w = (m_op == 1) ? m_data : ((m_rd & ~m_mask) | (m_data & m_mask));
      chk((m_op == 1) ? "R9" : "R7", "bus_wdata", bus_wdata, exp_w);
    end

    // slave: waitrequest, possibly raised in the same cycle a request appears
    req_now = bus_read || bus_write;
    if (req_now && !req_prev)
      stall_left = (mode == 0) ? 0 : int'($urandom_range(0, 4));
    if (req_now) begin
      bus_waitreq = (stall_left > 0);
      if (stall_left > 0) stall_left--;
    end else begin
      bus_waitreq = (mode == 1) ? ($urandom_range(0, 1) == 1) : 1'b0;
    end
    req_prev = req_now;

    // slave: read data with latency; stray valid pulses (R5) only when no read awaits data
    if (pend && lat_left == 0) begin
      bus_rdata_valid = 1'b1;
      bus_rdata = mem[bus_addr[3:0]];
      pend = 0;
    end else if (pend) begin
      lat_left--;
      bus_rdata_valid = 1'b0;
    end else if (mode == 1 && m_ph != 2 && $urandom_range(0, 3) == 0) begin
      bus_rdata_valid = 1'b1;
      bus_rdata = $urandom;
    end else begin
      bus_rdata_valid = 1'b0;
    end

    // commands on random cycles, busy or not (R2 ignore path)
    if (run && $urandom_range(0, 2) == 0) begin
      cmd_valid = 1'b1;
      cmd_op    = 2'($urandom_range(0, 3));
      cmd_addr  = 14'($urandom_range(0, 15));
      cmd_mask  = $urandom;
      cmd_data  = $urandom;
    end else begin
      cmd_valid = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA5A50000 + 32'(i * 32'h1111);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    run = 1;
    mode = 0;
    repeat (RUN_CYCLES / 4) @(posedge clk);
    mode = 1;
    repeat (RUN_CYCLES) @(posedge clk);
    run = 0;
    repeat (40) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule